// File: doc/BRIEF.md
# MPU Programming Register File

This block is the register file through which software programs a memory protection unit. A simple bus slave port carries an offset, read and write strobes, 32-bit write data and a size flag that selects word or halfword access. Behind that port sit a read-only type register, a three-bit control register, an indirect region selector, and per-region storage for a base address, a 16-bit size half and a 16-bit attribute half. The number of regions is a parameter from 0 to 16.

The selected region's settings and the control bits are presented continuously on output ports for a downstream address checker. Any accepted write that can change the protection map raises a one-cycle pulse that a lookup cache uses to flush. The base-address register has three alias windows. A write to it can also move the region selector when its valid bit is set. The attribute/size register has three alias windows as well, and it can also be accessed one 16-bit half at a time.

Top module: `mpu_regbank`

## Requirements
- R1: After reset the control bits, the region selector and every region's base, size and attribute halves are zero, and all outputs are zero.
- R2: A word read at offset 0xD90 returns the region count in bits [15:8] and zeros elsewhere.
- R3: A word write at 0xD94 keeps wdata bits [2:0] (bit 0 enable, bit 1 fault-handler enable, bit 2 privileged default map), which drive ctrl_en_o, ctrl_fault_en_o and ctrl_privdef_o and read back in bits [2:0].
- R4: A word write at 0xD98 takes wdata[7:0] as the region selector only when that value is below the region count, otherwise the old selection stays; a read returns the selector.
- R5: A word write at 0xD9C, 0xDA4, 0xDAC or 0xDB4 first sets the selector to wdata[3:0] when wdata[4] is 1 and wdata[3:0] is below the region count, then stores wdata with bits [4:0] cleared as the selected region's base.
- R6: A word read at any base window returns the selected region's stored base ORed with the selector.
- R7: A word write at 0xDA0, 0xDA8, 0xDB0 or 0xDB8 stores wdata[31:16] as the attribute half and wdata[15:0] as the size half of the selected region; a word read there returns {attribute, size}.
- R8: A halfword access (half_i=1) in 0xDA0..0xDB7 reaches the size half when offset mod 8 is 0 and the attribute half when offset mod 8 is 2, with data in bits [15:0]; a halfword write changes only that half. Any other halfword access reads 0 and has no effect.
- R9: With zero regions the control, base and attribute/size writes are ignored, the base and attribute/size reads return 0 and no pulse is raised.
- R10: map_chg_o is high for one cycle in the cycle after each accepted control, base or attribute/size write (word or halfword) and low otherwise.
- R11: An access to any unmapped offset reads 0 and changes nothing.
- R12: sel_region_o shows the selector; rgn_base_o shows the selected base; rgn_en_o is size bit 0, rgn_size_o is size bits [5:1] and rgn_ap_o is attribute bits [10:8].
- R13: rdata_o holds the addressed value in the cycle after rd_i and is 0 after a cycle without rd_i; when a read and write happen in the same cycle the read returns the state before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| half_i | input | 1 | 1 = halfword access, 0 = word access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ctrl_en_o | output | 1 | Protection enable |
| ctrl_fault_en_o | output | 1 | Enable while in fault handlers |
| ctrl_privdef_o | output | 1 | Privileged default map enable |
| sel_region_o | output | 8 | Current region selector |
| rgn_base_o | output | 32 | Base address of the selected region |
| rgn_en_o | output | 1 | Selected region enable |
| rgn_size_o | output | 5 | Selected region size code |
| rgn_ap_o | output | 3 | Selected region access permission |
| map_chg_o | output | 1 | One-cycle mapping-changed pulse |

## Verification
A base-window write with its valid bit set both moves the selector and stores into the newly chosen region within the same edge. A read and a write to the same register can also share a cycle. The bench provokes both: it writes a base with a selector in its low bits and checks that the selector, the stored base and the region outputs all move to the new region together. It also raises rd_i and wr_i together on the attribute window and expects the old contents back while the new contents appear on the region outputs. A behavioural model judges every cycle, and a second instance with zero regions runs on the same stimulus and must stay all zero.

// File: rtl/mpu_regbank_pkg.sv
package mpu_regbank_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'hD90;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'hD94;
  localparam logic [ADDR_W-1:0] OFS_SEL   = 12'hD98;
  localparam logic [ADDR_W-1:0] OFS_BASE0 = 12'hD9C;
  localparam logic [ADDR_W-1:0] OFS_ATTR0 = 12'hDA0;
  localparam logic [ADDR_W-1:0] OFS_WIN_HI = 12'hDB7;
  localparam int unsigned WIN_STRIDE = 8;
  localparam int unsigned NUM_WIN    = 4;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_TYPE,
    ACC_CTRL,
    ACC_SEL,
    ACC_BASE,
    ACC_ATTR_W,
    ACC_SIZE_H,
    ACC_ATTR_H
  } acc_e;

  typedef struct packed {
    logic priv_def;
    logic fault_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/mpu_addr_dec.sv
module mpu_addr_dec
  import mpu_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              half_i,
  output acc_e              kind_o
);
  logic [NUM_WIN-1:0] hit_base, hit_attr;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit_base[w] = addr_i == OFS_BASE0 + ADDR_W'(w * WIN_STRIDE);
    assign hit_attr[w] = addr_i == OFS_ATTR0 + ADDR_W'(w * WIN_STRIDE);
  end

  always_comb begin
    kind_o = ACC_NONE;
    if (!half_i) begin
      if (addr_i == OFS_TYPE)      kind_o = ACC_TYPE;
      else if (addr_i == OFS_CTRL) kind_o = ACC_CTRL;
      else if (addr_i == OFS_SEL)  kind_o = ACC_SEL;
      else if (|hit_base)          kind_o = ACC_BASE;
      else if (|hit_attr)          kind_o = ACC_ATTR_W;
    end else if (addr_i >= OFS_ATTR0 && addr_i <= OFS_WIN_HI) begin
      // halfword lanes of the attribute/size windows
      if (addr_i[2:0] == 3'd0)      kind_o = ACC_SIZE_H;
      else if (addr_i[2:0] == 3'd2) kind_o = ACC_ATTR_H;
    end
  end
endmodule

// File: rtl/mpu_region_store.sv
module mpu_region_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_base_i,
  input  logic             we_size_i,
  input  logic             we_attr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [26:0]      base_i,
  input  logic [15:0]      size_i,
  input  logic [15:0]      attr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [26:0]      base_o,
  output logic [15:0]      size_o,
  output logic [15:0]      attr_o
);
  logic [26:0] base_q [DEPTH];
  logic [15:0] size_q [DEPTH];
  logic [15:0] attr_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rgn
    logic hit;
    assign hit = wr_idx_i == IDX_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
        size_q[g] <= '0;
        attr_q[g] <= '0;
      end else begin
        if (we_base_i && hit) base_q[g] <= base_i;
        if (we_size_i && hit) size_q[g] <= size_i;
        if (we_attr_i && hit) attr_q[g] <= attr_i;
      end
    end
  end

  always_comb begin
    base_o = '0;
    size_o = '0;
    attr_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        base_o = base_q[i];
        size_o = size_q[i];
        attr_o = attr_q[i];
      end
    end
  end
endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank
  import mpu_regbank_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              half_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ctrl_en_o,
  output logic              ctrl_fault_en_o,
  output logic              ctrl_privdef_o,
  output logic [7:0]        sel_region_o,
  output logic [31:0]       rgn_base_o,
  output logic              rgn_en_o,
  output logic [4:0]        rgn_size_o,
  output logic [2:0]        rgn_ap_o,
  output logic              map_chg_o
);
  localparam int unsigned IDX_W   = 8;
  localparam bit          HAS_RGN = NUM_REGIONS > 0;
  localparam int unsigned DEPTH   = HAS_RGN ? NUM_REGIONS : 1;
  localparam logic [IDX_W-1:0] CNT = IDX_W'(NUM_REGIONS);

  acc_e             kind;
  ctrl_t            ctrl_q;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             we_ctrl, we_base, we_size, we_attr, base_sel_ok;
  logic [26:0]      base_rd;
  logic [15:0]      size_rd, attr_rd, attr_wd;
  logic [31:0]      rd_val, rdata_q;
  logic             chg_q;

  mpu_addr_dec u_dec (
    .addr_i (addr_i),
    .half_i (half_i),
    .kind_o (kind)
  );

  assign base_sel_ok = wdata_i[4] && ({4'b0, wdata_i[3:0]} < CNT);

  assign we_ctrl = HAS_RGN && wr_i && kind == ACC_CTRL;
  assign we_base = HAS_RGN && wr_i && kind == ACC_BASE;
  assign we_size = HAS_RGN && wr_i && (kind == ACC_ATTR_W || kind == ACC_SIZE_H);
  assign we_attr = HAS_RGN && wr_i && (kind == ACC_ATTR_W || kind == ACC_ATTR_H);
  assign attr_wd = (kind == ACC_ATTR_W) ? wdata_i[31:16] : wdata_i[15:0];

  // selector moves before the base store lands
  always_comb begin
    sel_d = sel_q;
    if (wr_i && kind == ACC_SEL && wdata_i[7:0] < CNT) sel_d = wdata_i[7:0];
    else if (we_base && base_sel_ok)                  sel_d = {4'b0, wdata_i[3:0]};
  end

  mpu_region_store #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_base_i (we_base),
    .we_size_i (we_size),
    .we_attr_i (we_attr),
    .wr_idx_i  (sel_d),
    .base_i    (wdata_i[31:5]),
    .size_i    (wdata_i[15:0]),
    .attr_i    (attr_wd),
    .rd_idx_i  (sel_q),
    .base_o    (base_rd),
    .size_o    (size_rd),
    .attr_o    (attr_rd)
  );

  always_comb begin
    rd_val = '0;
    unique case (kind)
      ACC_TYPE: rd_val = {16'b0, CNT, 8'b0};
      ACC_CTRL: rd_val = {29'b0, ctrl_q};
      ACC_SEL:  rd_val = {24'b0, sel_q};
      ACC_BASE:   if (HAS_RGN) rd_val = {base_rd, 5'b0} | {24'b0, sel_q};
      ACC_ATTR_W: if (HAS_RGN) rd_val = {attr_rd, size_rd};
      ACC_SIZE_H: if (HAS_RGN) rd_val = {16'b0, size_rd};
      ACC_ATTR_H: if (HAS_RGN) rd_val = {16'b0, attr_rd};
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_q <= ctrl_t'(wdata_i[2:0]);
      sel_q   <= sel_d;
      rdata_q <= rd_i ? rd_val : '0;
      chg_q   <= we_ctrl || we_base || we_size || we_attr;
    end
  end

  assign rdata_o         = rdata_q;
  assign map_chg_o       = chg_q;
  assign ctrl_en_o       = ctrl_q.en;
  assign ctrl_fault_en_o = ctrl_q.fault_en;
  assign ctrl_privdef_o  = ctrl_q.priv_def;
  assign sel_region_o    = sel_q;
  assign rgn_base_o      = HAS_RGN ? {base_rd, 5'b0} : '0;
  assign rgn_en_o        = HAS_RGN && size_rd[0];
  assign rgn_size_o      = HAS_RGN ? size_rd[5:1] : '0;
  assign rgn_ap_o        = HAS_RGN ? attr_rd[10:8] : '0;
endmodule

// File: rtl/mpu_regbank_chk.sv
module mpu_regbank_chk #(
  parameter int unsigned NUM_REGIONS = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [11:0] addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic        half_i,
  input logic [31:0] rdata_o,
  input logic        ctrl_en_o,
  input logic        ctrl_fault_en_o,
  input logic        ctrl_privdef_o,
  input logic [7:0]  sel_region_o,
  input logic [31:0] rgn_base_o,
  input logic        map_chg_o
);
  localparam int unsigned SEL_LIM = (NUM_REGIONS == 0) ? 1 : NUM_REGIONS;

  a_r2_type_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !half_i && addr_i == 12'hD90) |=> rdata_o == (32'(NUM_REGIONS) << 8));

  a_r13_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == 32'd0);

  a_r3_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({ctrl_en_o, ctrl_fault_en_o, ctrl_privdef_o}));

  a_r4_sel_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sel_region_o) < SEL_LIM);

  a_r5_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rgn_base_o[4:0] == 5'd0);

  a_r10_chg_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_chg_o |-> $past(wr_i));

  a_r10_ctrl_write_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_REGIONS > 0 && wr_i && !half_i && addr_i == 12'hD94) |=> map_chg_o);
endmodule

bind mpu_regbank mpu_regbank_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .addr_i          (addr_i),
  .wr_i            (wr_i),
  .rd_i            (rd_i),
  .half_i          (half_i),
  .rdata_o         (rdata_o),
  .ctrl_en_o       (ctrl_en_o),
  .ctrl_fault_en_o (ctrl_fault_en_o),
  .ctrl_privdef_o  (ctrl_privdef_o),
  .sel_region_o    (sel_region_o),
  .rgn_base_o      (rgn_base_o),
  .map_chg_o       (map_chg_o)
);

// File: tb/mpu_regbank_tb.sv
module mpu_regbank_tb;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0, half = 1'b0;
  logic [31:0] wdata = '0;

  logic [31:0] rdata, base_o, z_rdata, z_base;
  logic        c_en, c_fe, c_pd, r_en, chg;
  logic        z_c_en, z_c_fe, z_c_pd, z_r_en, z_chg;
  logic [7:0]  sel, z_sel;
  logic [4:0]  r_size, z_size;
  logic [2:0]  r_ap, z_ap;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  mpu_regbank #(.NUM_REGIONS(NR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .half_i(half),
    .wdata_i(wdata), .rdata_o(rdata), .ctrl_en_o(c_en), .ctrl_fault_en_o(c_fe),
    .ctrl_privdef_o(c_pd), .sel_region_o(sel), .rgn_base_o(base_o), .rgn_en_o(r_en),
    .rgn_size_o(r_size), .rgn_ap_o(r_ap), .map_chg_o(chg));

  mpu_regbank #(.NUM_REGIONS(0)) u_dut0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .half_i(half),
    .wdata_i(wdata), .rdata_o(z_rdata), .ctrl_en_o(z_c_en), .ctrl_fault_en_o(z_c_fe),
    .ctrl_privdef_o(z_c_pd), .sel_region_o(z_sel), .rgn_base_o(z_base), .rgn_en_o(z_r_en),
    .rgn_size_o(z_size), .rgn_ap_o(z_ap), .map_chg_o(z_chg));

  // behavioural reference model
  int          m_ctrl, m_sel;
  logic [31:0] m_base [NR];
  logic [15:0] m_size [NR];
  logic [15:0] m_attr [NR];
  logic [31:0] m_rdata;
  bit          m_chg;

  // 0 none,1 type,2 ctrl,3 sel,4 base,5 attr word,6 size half,7 attr half
  function automatic int kind_of(int a, bit h);
    if (h) begin
      if (a >= 'hDA0 && a <= 'hDB7 && a % 8 == 0) return 6;
      if (a >= 'hDA0 && a <= 'hDB7 && a % 8 == 2) return 7;
      return 0;
    end
    if (a == 'hD90) return 1;
    if (a == 'hD94) return 2;
    if (a == 'hD98) return 3;
    if (a >= 'hD9C && a <= 'hDB4 && (a - 'hD9C) % 8 == 0) return 4;
    if (a >= 'hDA0 && a <= 'hDB8 && (a - 'hDA0) % 8 == 0) return 5;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sel = 0; m_rdata = 0; m_chg = 0;
      for (int i = 0; i < NR; i++) begin m_base[i] = 0; m_size[i] = 0; m_attr[i] = 0; end
    end else begin
      int k;
      k = kind_of(int'(addr), half);
      m_rdata = 0;
      if (rd) case (k)
        1: m_rdata = NR * 256;
        2: m_rdata = m_ctrl;
        3: m_rdata = m_sel;
        4: m_rdata = m_base[m_sel] | m_sel;
        5: m_rdata = {m_attr[m_sel], m_size[m_sel]};
        6: m_rdata = {16'h0, m_size[m_sel]};
        7: m_rdata = {16'h0, m_attr[m_sel]};
        default: m_rdata = 0;
      endcase
      m_chg = 0;
      if (wr) case (k)
        2: begin m_ctrl = int'(wdata & 7); m_chg = 1; end
        3: if (int'(wdata & 255) < NR) m_sel = int'(wdata & 255);
        4: begin
          if (wdata[4] && int'(wdata[3:0]) < NR) m_sel = int'(wdata[3:0]);
          m_base[m_sel] = wdata & ~32'h1F; m_chg = 1;
        end
        5: begin m_attr[m_sel] = wdata[31:16]; m_size[m_sel] = wdata[15:0]; m_chg = 1; end
        6: begin m_size[m_sel] = wdata[15:0]; m_chg = 1; end
        7: begin m_attr[m_sel] = wdata[15:0]; m_chg = 1; end
        default: ;
      endcase
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, "rdata", rdata, m_rdata);
    chk("R10", "map_chg", 32'(chg), 32'(m_chg));
    chk("R3", "ctrl outs", {29'h0, c_pd, c_fe, c_en}, 32'(m_ctrl));
    chk("R12", "sel_region", 32'(sel), 32'(m_sel));
    chk("R12", "rgn_base", base_o, m_base[m_sel]);
    chk("R12", "rgn_en", 32'(r_en), 32'(m_size[m_sel][0]));
    chk("R12", "rgn_size", 32'(r_size), 32'(m_size[m_sel][5:1]));
    chk("R12", "rgn_ap", 32'(r_ap), 32'(m_attr[m_sel][10:8]));
    // zero-region instance must stay silent on the same stimulus (R9)
    chk("R9", "zero rdata", z_rdata, 32'h0);
    chk("R9", "zero outs", {z_base[23:0], z_sel}, 32'h0);
    chk("R9", "zero misc", {19'h0, z_chg, z_c_en, z_c_fe, z_c_pd, z_r_en, z_size, z_ap}, 32'h0);
  endtask

  task automatic step(bit w, bit r, bit h, int a, logic [31:0] d);
    @(negedge clk);
    compare();
    wr = w; rd = r; half = h; addr = 12'(a); wdata = d;
  endtask

  task automatic wr_w(int a, logic [31:0] d); step(1, 0, 0, a, d); endtask
  task automatic wr_h(int a, logic [15:0] d); step(1, 0, 1, a, {16'hA5A5, d}); endtask
  task automatic rd_w(int a); step(0, 1, 0, a, 0); endtask
  task automatic rd_h(int a); step(0, 1, 1, a, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0); endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    idle(); rd_w('hD94); rd_w('hD98); rd_w('hD9C); rd_w('hDA0); idle();
    // R2 type register
    cur_req = "R2";
    rd_w('hD90); rd_h('hD90); idle();
    // R3 control
    cur_req = "R3";
    wr_w('hD94, 32'hFFFF_FFFF); rd_w('hD94); wr_w('hD94, 32'h5); rd_w('hD94);
    wr_w('hD94, 32'h2); rd_w('hD94); idle();
    // R4 selector
    cur_req = "R4";
    wr_w('hD98, 3); rd_w('hD98); wr_w('hD98, 8); rd_w('hD98);
    wr_w('hD98, 32'h106); rd_w('hD98); wr_w('hD98, 32'hFF); rd_w('hD98); idle();
    // R5 base writes, valid bit and aliases
    cur_req = "R5";
    wr_w('hD9C, 32'h2000_00FF); rd_w('hD98);
    wr_w('hDA4, 32'h3000_0015); rd_w('hD98);
    wr_w('hDAC, 32'h4000_0012); wr_w('hDB4, 32'h5000_000F); rd_w('hD98); idle();
    // R6 base readback
    cur_req = "R6";
    rd_w('hD9C); rd_w('hDB4); wr_w('hD98, 5); rd_w('hDAC); rd_w('hDA4); idle();
    // R7 attribute/size words
    cur_req = "R7";
    wr_w('hDA0, 32'h0306_0011); rd_w('hDA8); wr_w('hD98, 2);
    wr_w('hDB8, 32'h0512_003F); rd_w('hDB0); rd_w('hDA0); idle();
    // R8 halfword lanes
    cur_req = "R8";
    wr_h('hDA2, 16'h0600); rd_h('hDA8); rd_h('hDAA); rd_w('hDA0);
    wr_h('hDB0, 16'h000B); rd_h('hDB2); rd_h('hDA0);
    wr_h('hDA4, 16'hFFFF); wr_h('hD94, 16'h7); wr_h('hDA1, 16'h1); rd_h('hDA6); rd_w('hDA0); idle();
    // R10 back-to-back writes keep pulsing
    cur_req = "R10";
    wr_w('hD94, 1); wr_w('hDA8, 32'h0100_0009); wr_h('hDAA, 16'h0200); idle(); idle();
    // R11 unmapped offsets
    cur_req = "R11";
    wr_w('hDBC, 32'hFFFF_FFFF); wr_w('hD00, 32'h1234); wr_w('hD9E, 32'hFFFF_FFFF);
    rd_w('hDBC); rd_w('hD9A); rd_w('hDA0); idle();
    // R12 walk regions: outputs follow the selector
    cur_req = "R12";
    for (int i = 0; i < NR; i++) begin
      wr_w('hD9C, 32'h0010_0000 * (i + 1) | 32'h10 | i);
      wr_h('hDA0, 16'(2 * i + 1));
      wr_h('hDA2, 16'(i << 8));
    end
    for (int i = 0; i < NR; i++) begin wr_w('hD98, i); idle(); end
    // R13 same-cycle read and write return pre-write contents
    cur_req = "R13";
    step(1, 1, 0, 'hDA0, 32'h0700_0021); step(1, 1, 1, 'hDA2, 16'h0300);
    step(1, 1, 0, 'hD9C, 32'h7000_0013); step(1, 1, 0, 'hD94, 32'h4);
    rd_w('hD9C); idle(); idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule